// File: doc/BRIEF.md
# Four-Character Command Mailbox

This block is the register side of a host command path. It has two channels, and each one owns a 32-bit command register and a byte-wide data register. The host loads optional input bytes into a channel's data register. It then writes four ASCII characters into that channel's command register. The fourth command byte starts the command.

If the code is in the recognised set, the channel raises a request to an external handler and holds the code steady until the handler reports done. The completion code is then written back into the command register: all zeros on success, or the four characters `!CMD` on failure. On success the handler's output bytes replace the data register. Every completion sets the channel's bit in an event register. The host can poll the command register, or it can unmask that bit and wait for the interrupt line.

Host access is byte-serial. An access opens with a start strobe that carries the register address, and each following byte write or byte read moves an internal byte pointer forward. Every register read first returns a byte count and then the content bytes.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset both command registers read 0x00000000, both data registers have length 0, event and mask registers are 0, `irq` is low and no handler request is raised.
- R2: A read returns a length byte first and then the content. Command registers (ch1 at 0x08, ch2 at 0x10) read length 4 and return the characters in the order they were written. Data registers (ch1 at 0x09, ch2 at 0x11) return their current length and then that many bytes. The event (0x20) and mask (0x21) registers read length 1 and then their value.
- R3: Byte k of a data-register write stores byte k. The length becomes the number of bytes written in that access, capped at DATA_BYTES. Bytes past DATA_BYTES are dropped.
- R4: The fourth byte written to an idle command register starts the command. If the code is one of "SWAP", "GCAP", "PTCH" or "RDID", `hnd_req` for that channel is high from the next cycle. While it is high, `hnd_code` carries the code and `hnd_idata`/`hnd_ilen` carry the data register.
- R5: Any other code completes in that same cycle. The command register then reads "!CMD", the event bit is set and no request is raised.
- R6: When the handler reports done with ok=1, the command register reads 0x00000000. The data register then holds the handler output, with length min(`hnd_olen`, DATA_BYTES).
- R7: When the handler reports done with ok=0, the command register reads "!CMD" and the data register is left unchanged.
- R8: Every completion sets the event bit for its channel: bit 0 for channel 1, bit 1 for channel 2.
- R9: Writing a byte to the clear register (0x22) clears each event bit whose matching data bit is 1. A completion in the same cycle wins over the clear.
- R10: `irq` is high exactly when some event bit is set whose mask bit is also 1.
- R11: While a channel is busy, writes to its command and data registers are ignored. The command register keeps reading the busy code.
- R12: The two channels run independently: one can complete while the other is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | Opens a host access at `acc_addr` and resets the byte pointer |
| acc_addr | input | 8 | Register address for the access |
| acc_wr | input | 1 | Writes `acc_wdata` at the byte pointer, then advances it |
| acc_wdata | input | 8 | Write byte |
| acc_rd | input | 1 | Advances the byte pointer after a read |
| acc_rdata | output | 8 | Byte at the current pointer |
| irq | output | 1 | Interrupt: any unmasked event |
| hnd_req | output | 2 | Per-channel handler request (busy) |
| hnd_code | output | 64 | Per-channel command code, 32 bits each |
| hnd_idata | output | 2*DATA_BYTES*8 | Per-channel data register content |
| hnd_ilen | output | 16 | Per-channel data length |
| hnd_done | input | 2 | Per-channel handler completion strobe |
| hnd_ok | input | 2 | Per-channel success flag, sampled with done |
| hnd_odata | input | 2*DATA_BYTES*8 | Per-channel handler output bytes |
| hnd_olen | input | 16 | Per-channel handler output length |

## Verification
Seeded random rounds mix three things: data writes of every length from zero to past capacity, recognised and arbitrary command codes, and handler outcomes with random output lengths. Comparing against a bench model separates the success write-back from the failure write-back, and shows that data survives a failure. Directed cases cover the rest. A command and a data write are issued to a busy channel, which shows that both are ignored. The other channel completes meanwhile, which shows the channels are independent. A clear lands in the same cycle as a completion, which fixes the set-over-clear priority. Mask patterns are stepped through to tell masked events apart from unmasked ones on `irq`.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // Number of mailbox channels; the address map below is laid out for two.
    localparam int NCH = 2;
    localparam int CODE_W = 32;

    localparam logic [7:0] A_EVENT = 8'h20;
    localparam logic [7:0] A_MASK  = 8'h21;
    localparam logic [7:0] A_CLEAR = 8'h22;

    localparam logic [CODE_W-1:0] FAIL_CODE = "!CMD";

    // Recognised command codes; entry i sits at bits [i*32 +: 32].
    localparam int NUM_CODES = 4;
    localparam logic [NUM_CODES*CODE_W-1:0] KNOWN_CODES = {"RDID", "PTCH", "GCAP", "SWAP"};

    typedef enum logic {CH_IDLE, CH_BUSY} ch_state_e;

    function automatic logic [7:0] cmd_addr(input int ch);
        return (ch == 0) ? 8'h08 : 8'h10;
    endfunction

    function automatic logic [7:0] data_addr(input int ch);
        return (ch == 0) ? 8'h09 : 8'h11;
    endfunction
endpackage

// File: rtl/mbx_decode.sv
// mbx_decode: matches a 32-bit command code against the recognised set.
// Assumes: purely combinational; the code table lives in mbx_pkg.
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              known
);
    logic [NUM_CODES-1:0] hit;

    // One comparator per table entry.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_cmp
        assign hit[i] = (code == KNOWN_CODES[i*CODE_W +: CODE_W]);
    end

    assign known = |hit;
endmodule

// File: rtl/mbx_channel.sv
// mbx_channel: one mailbox channel holding the command register, the data
// register and the idle/busy sequencing with the handler.
// Assumes: wr_idx is the byte offset within the current host access;
// hnd_done is a one-cycle strobe and only matters while busy.
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int DATA_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic                    data_wr,
    input  logic [7:0]              wr_idx,
    input  logic [7:0]              wdata,
    input  logic                    hnd_done,
    input  logic                    hnd_ok,
    input  logic [DATA_BYTES*8-1:0] hnd_odata,
    input  logic [7:0]              hnd_olen,
    output logic [CODE_W-1:0]       cmd_value,
    output logic [DATA_BYTES*8-1:0] data_value,
    output logic [7:0]              data_len,
    output logic                    busy,
    output logic                    done_evt
);
    localparam logic [7:0] DB_L = 8'(DATA_BYTES);

    ch_state_e               state;
    logic [CODE_W-1:0]       cmd_q;
    logic [CODE_W-1:0]       cmd_asm;
    logic [DATA_BYTES*8-1:0] data_q;
    logic [7:0]              len_q;
    logic                    known;
    logic                    idle;
    logic                    trig;
    logic                    finish;

    assign idle = (state == CH_IDLE);

    // Command value as it would be with the incoming byte merged in (first char in MSB).
    always_comb begin
        cmd_asm = cmd_q;
        for (int b = 0; b < 4; b++) begin
            if (wr_idx == 8'(b)) cmd_asm[CODE_W-1-8*b -: 8] = wdata;
        end
    end

    mbx_decode u_dec (
        .code  (cmd_asm),
        .known (known)
    );

    assign trig     = cmd_wr && idle && (wr_idx == 8'd3);
    assign finish   = (state == CH_BUSY) && hnd_done;
    assign done_evt = (trig && !known) || finish;

    // Command register and channel state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            cmd_q <= '0;
        end else if (finish) begin
            state <= CH_IDLE;
            cmd_q <= hnd_ok ? '0 : FAIL_CODE;
        end else if (trig) begin
            if (known) begin
                state <= CH_BUSY;
                cmd_q <= cmd_asm;
            end else begin
                cmd_q <= FAIL_CODE;
            end
        end else if (cmd_wr && idle && (wr_idx < 8'd4)) begin
            cmd_q <= cmd_asm;
        end
    end

    // Data register: host fills it while idle, handler replaces it on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            len_q  <= '0;
        end else if (finish && hnd_ok) begin
            data_q <= hnd_odata;
            len_q  <= (hnd_olen > DB_L) ? DB_L : hnd_olen;
        end else if (data_wr && idle && (wr_idx < DB_L)) begin
            data_q[int'(wr_idx)*8 +: 8] <= wdata;
            len_q                       <= wr_idx + 8'd1;
        end
    end

    assign cmd_value  = cmd_q;
    assign data_value = data_q;
    assign data_len   = len_q;
    assign busy       = (state == CH_BUSY);

    // R11: a busy command holds its value until the handler finishes.
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hnd_done) |=> $stable(cmd_value));
    // R5: an unknown code completes at once with the failure string.
    p_unknown_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !known) |=> (cmd_value == FAIL_CODE) && !busy);
    // R6: a successful finish reads back zero.
    p_ok_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hnd_done && hnd_ok) |=> (cmd_value == '0) && !busy);
    // R7: a failed finish reads back the failure string and keeps the data.
    p_fail_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hnd_done && !hnd_ok) |=> (cmd_value == FAIL_CODE) && $stable(data_value));
endmodule

// File: rtl/mbx_events.sv
// mbx_events: event, mask and clear registers plus the interrupt output.
// Assumes: set strobes come from the channels; clear/mask writes are single
// byte strobes; a set wins over a clear in the same cycle.
module mbx_events
    import mbx_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set,
    input  logic           clr_wr,
    input  logic           mask_wr,
    input  logic [7:0]     wdata,
    output logic [NCH-1:0] evt,
    output logic [NCH-1:0] mask,
    output logic           irq
);
    // Event bits: sticky set, write-one clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt <= '0;
        end else begin
            evt <= (evt & ~(clr_wr ? wdata[NCH-1:0] : '0)) | set;
        end
    end

    // Mask register written by host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_wr) begin
            mask <= wdata[NCH-1:0];
        end
    end

    assign irq = |(evt & mask);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R8: a completion always leaves its event bit set.
        p_evt_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> evt[i]);
        // R9: a clear without a simultaneous completion removes the bit.
        p_evt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && wdata[i] && !set[i]) |=> !evt[i]);
    end
    // R10: the interrupt only rises after a completion or a mask change.
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|set || mask_wr));
endmodule

// File: rtl/cmd_mailbox.sv
// cmd_mailbox: two-channel four-character command mailbox with byte-serial
// host access, handler handshake and interrupt events.
// Assumes: acc_start opens an access; acc_wr/acc_rd never coincide with
// acc_start; every register read begins with a length byte.
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_BYTES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_start,
    input  logic [7:0]                  acc_addr,
    input  logic                        acc_wr,
    input  logic                        acc_rd,
    input  logic [7:0]                  acc_wdata,
    output logic [7:0]                  acc_rdata,
    output logic                        irq,
    output logic [NCH-1:0]              hnd_req,
    output logic [NCH*CODE_W-1:0]       hnd_code,
    output logic [NCH*DATA_BYTES*8-1:0] hnd_idata,
    output logic [NCH*8-1:0]            hnd_ilen,
    input  logic [NCH-1:0]              hnd_done,
    input  logic [NCH-1:0]              hnd_ok,
    input  logic [NCH*DATA_BYTES*8-1:0] hnd_odata,
    input  logic [NCH*8-1:0]            hnd_olen
);
    localparam int DW = DATA_BYTES * 8;

    logic [7:0]        sel_q;
    logic [7:0]        ptr_q;
    logic [NCH-1:0]    ch_done;
    logic [CODE_W-1:0] ch_cmd  [NCH];
    logic [DW-1:0]     ch_data [NCH];
    logic [7:0]        ch_len  [NCH];
    logic [NCH-1:0]    evt;
    logic [NCH-1:0]    mask;
    logic              wr_go;

    assign wr_go = acc_wr && !acc_start;

    // Access address and saturating byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ptr_q <= '0;
        end else if (acc_start) begin
            sel_q <= acc_addr;
            ptr_q <= '0;
        end else if ((acc_wr || acc_rd) && (ptr_q != 8'hFF)) begin
            ptr_q <= ptr_q + 8'd1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mbx_channel #(.DATA_BYTES(DATA_BYTES)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_wr     (wr_go && (sel_q == cmd_addr(c))),
            .data_wr    (wr_go && (sel_q == data_addr(c))),
            .wr_idx     (ptr_q),
            .wdata      (acc_wdata),
            .hnd_done   (hnd_done[c]),
            .hnd_ok     (hnd_ok[c]),
            .hnd_odata  (hnd_odata[c*DW +: DW]),
            .hnd_olen   (hnd_olen[c*8 +: 8]),
            .cmd_value  (ch_cmd[c]),
            .data_value (ch_data[c]),
            .data_len   (ch_len[c]),
            .busy       (hnd_req[c]),
            .done_evt   (ch_done[c])
        );
        assign hnd_code[c*CODE_W +: CODE_W] = ch_cmd[c];
        assign hnd_idata[c*DW +: DW]        = ch_data[c];
        assign hnd_ilen[c*8 +: 8]           = ch_len[c];
    end

    mbx_events u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (ch_done),
        .clr_wr  (wr_go && (sel_q == A_CLEAR) && (ptr_q == 8'd0)),
        .mask_wr (wr_go && (sel_q == A_MASK) && (ptr_q == 8'd0)),
        .wdata   (acc_wdata),
        .evt     (evt),
        .mask    (mask),
        .irq     (irq)
    );

    // Read mux: length byte at pointer 0, content bytes after it.
    always_comb begin
        logic [7:0] idx;
        idx       = ptr_q - 8'd1;
        acc_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (sel_q == cmd_addr(c)) begin
                if (ptr_q == 8'd0)     acc_rdata = 8'd4;
                else if (ptr_q <= 8'd4) acc_rdata = ch_cmd[c][CODE_W-1-8*int'(idx) -: 8];
            end
            if (sel_q == data_addr(c)) begin
                if (ptr_q == 8'd0)         acc_rdata = ch_len[c];
                else if (idx < ch_len[c])  acc_rdata = ch_data[c][int'(idx)*8 +: 8];
            end
        end
        if (sel_q == A_EVENT || sel_q == A_MASK || sel_q == A_CLEAR) begin
            if (ptr_q == 8'd0)      acc_rdata = 8'd1;
            else if (ptr_q == 8'd1) acc_rdata = (sel_q == A_EVENT) ? 8'(evt) :
                                                (sel_q == A_MASK)  ? 8'(mask) : 8'd0;
        end
    end

    // R1: nothing is requested or signalled in the cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (hnd_req == '0) && !irq);
    // R12: a completion on one channel leaves the other channel's request alone.
    p_indep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done[0] && hnd_req[1] && !hnd_done[1]) |=> hnd_req[1]);
endmodule

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;
    localparam int CLK_PERIOD = 10;
    localparam int DB = 8;
    localparam int DW = DB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_start = 1'b0, acc_wr = 1'b0, acc_rd = 1'b0;
    logic [7:0] acc_addr = '0, acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic irq;
    logic [1:0] hnd_req;
    logic [63:0] hnd_code;
    logic [2*DW-1:0] hnd_idata;
    logic [15:0] hnd_ilen;
    logic [1:0] hnd_done = '0, hnd_ok = '0;
    logic [2*DW-1:0] hnd_odata = '0;
    logic [15:0] hnd_olen = '0;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    logic [7:0] wbuf [0:15];
    logic [7:0] rbuf [0:15];
    logic [7:0] ebuf [0:15];
    int elen;

    logic [31:0] exp_cmd [2];
    logic [7:0]  exp_data [2][DB];
    int          exp_len [2];
    logic [1:0]  exp_evt;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_mailbox #(.DATA_BYTES(DB)) uut (.*);

    function automatic logic [7:0] a_cmd(input int ch);
        return ch == 0 ? 8'h08 : 8'h10;
    endfunction
    function automatic logic [7:0] a_data(input int ch);
        return ch == 0 ? 8'h09 : 8'h11;
    endfunction
    function automatic bit is_known(input logic [31:0] c);
        return c == "SWAP" || c == "GCAP" || c == "PTCH" || c == "RDID";
    endfunction
    function automatic int min_db(input int n);
        return n > DB ? DB : n;
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input int n);
        acc_start = 1; acc_addr = a; cyc(); acc_start = 0;
        for (int i = 0; i < n; i++) begin
            acc_wr = 1; acc_wdata = wbuf[i]; cyc();
        end
        acc_wr = 0;
    endtask

    task automatic wr_cmd(input int ch, input logic [31:0] code);
        for (int i = 0; i < 4; i++) wbuf[i] = code[31-8*i -: 8];
        wr_reg(a_cmd(ch), 4);
    endtask

    task automatic rd_reg(input logic [7:0] a, input int n);
        acc_start = 1; acc_addr = a; cyc(); acc_start = 0;
        for (int i = 0; i < n; i++) begin
            rbuf[i] = acc_rdata; acc_rd = 1; cyc();
        end
        acc_rd = 0;
    endtask

    task automatic check_read(input string req, input logic [7:0] a);
        rd_reg(a, elen + 1);
        for (int i = 0; i <= elen; i++)
            chk(req, $sformatf("addr %h byte %0d", a, i), 32'(rbuf[i]), 32'(ebuf[i]));
    endtask

    task automatic check_cmd(input string req, input int ch);
        ebuf[0] = 8'd4;
        for (int i = 0; i < 4; i++) ebuf[i+1] = exp_cmd[ch][31-8*i -: 8];
        elen = 4;
        check_read(req, a_cmd(ch));
    endtask

    task automatic check_data(input string req, input int ch);
        ebuf[0] = 8'(exp_len[ch]);
        for (int i = 0; i < exp_len[ch]; i++) ebuf[i+1] = exp_data[ch][i];
        elen = exp_len[ch];
        check_read(req, a_data(ch));
    endtask

    task automatic check_evt(input string req);
        ebuf[0] = 8'd1; ebuf[1] = 8'(exp_evt); elen = 1;
        check_read(req, 8'h20);
    endtask

    task automatic host_data(input int ch, input int n);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        wr_reg(a_data(ch), n);
        for (int i = 0; i < min_db(n); i++) exp_data[ch][i] = wbuf[i];
        if (n > 0) exp_len[ch] = min_db(n);
    endtask

    task automatic finish_cmd(input int ch, input bit ok, input int olen);
        for (int k = 0; k < DB; k++) hnd_odata[ch*DW + k*8 +: 8] = 8'($urandom);
        hnd_olen[ch*8 +: 8] = 8'(olen);
        hnd_ok[ch] = ok; hnd_done[ch] = 1; cyc(); hnd_done[ch] = 0;
        if (ok) begin
            exp_cmd[ch] = '0;
            for (int k = 0; k < DB; k++) exp_data[ch][k] = hnd_odata[ch*DW + k*8 +: 8];
            exp_len[ch] = min_db(olen);
        end else begin
            exp_cmd[ch] = "!CMD";
        end
        exp_evt[ch] = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            exp_cmd[c] = '0; exp_len[c] = 0;
            for (int k = 0; k < DB; k++) exp_data[c][k] = '0;
        end
        exp_evt = '0;
        repeat (3) cyc();
        rst_n = 1; cyc();

        // R1: reset state
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "hnd_req", 32'(hnd_req), 0);
        check_cmd("R1", 0); check_cmd("R1", 1);
        check_data("R1", 0); check_data("R1", 1);
        check_evt("R1");

        // R3: write past capacity is capped
        host_data(1, DB + 3);
        check_data("R3", 1);
        host_data(1, 2);
        check_data("R3", 1);

        // R11/R12/R9/R7 directed sequence
        host_data(0, 3);
        wr_cmd(0, "PTCH");
        exp_cmd[0] = "PTCH";
        chk("R4", "req0", 32'(hnd_req[0]), 1);
        chk("R4", "code0", hnd_code[31:0], "PTCH");
        wr_cmd(0, "GCAP");
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
        wr_reg(a_data(0), 2);
        check_cmd("R11", 0);
        check_data("R11", 0);
        wr_cmd(1, "ZZZZ");
        exp_cmd[1] = "!CMD"; exp_evt[1] = 1'b1;
        chk("R5", "req1", 32'(hnd_req[1]), 0);
        chk("R12", "req0 still busy", 32'(hnd_req[0]), 1);
        check_cmd("R5", 1);
        check_evt("R8");
        // clear both bits in the same cycle as channel 1 fails: set wins for bit 0
        acc_start = 1; acc_addr = 8'h22; cyc(); acc_start = 0;
        acc_wr = 1; acc_wdata = 8'h03;
        hnd_ok[0] = 0; hnd_done[0] = 1; hnd_olen[7:0] = 8'd5;
        cyc();
        acc_wr = 0; hnd_done[0] = 0;
        exp_cmd[0] = "!CMD"; exp_evt = 2'b01;
        check_evt("R9");
        check_cmd("R7", 0);
        check_data("R7", 0);

        // R10: interrupt masking
        chk("R10", "irq mask 0", 32'(irq), 0);
        wbuf[0] = 8'h02; wr_reg(8'h21, 1);
        chk("R10", "irq mask 2", 32'(irq), 0);
        wbuf[0] = 8'h01; wr_reg(8'h21, 1);
        chk("R10", "irq mask 1", 32'(irq), 1);
        ebuf[0] = 8'd1; ebuf[1] = 8'h01; elen = 1;
        check_read("R2", 8'h21);
        wbuf[0] = 8'h01; wr_reg(8'h22, 1); exp_evt = '0;
        chk("R10", "irq after clear", 32'(irq), 0);
        check_evt("R9");
        wbuf[0] = 8'h00; wr_reg(8'h21, 1);

        // random rounds
        for (int it = 0; it < 80; it++) begin
            int ch;
            logic [31:0] code;
            ch = int'($urandom % 2);
            host_data(ch, int'($urandom % (DB + 3)));
            if ($urandom % 2 == 0) begin
                case ($urandom % 4)
                    0: code = "SWAP";
                    1: code = "GCAP";
                    2: code = "PTCH";
                    default: code = "RDID";
                endcase
            end else begin
                code = $urandom;
            end
            wr_cmd(ch, code);
            if (is_known(code)) begin
                chk("R4", "req", 32'(hnd_req[ch]), 1);
                chk("R4", "code", hnd_code[ch*32 +: 32], code);
                chk("R4", "ilen", 32'(hnd_ilen[ch*8 +: 8]), 32'(exp_len[ch]));
                for (int k = 0; k < exp_len[ch]; k++)
                    chk("R4", "idata", 32'(hnd_idata[ch*DW + k*8 +: 8]), 32'(exp_data[ch][k]));
                exp_cmd[ch] = code;
                repeat (int'($urandom % 3)) cyc();
                chk("R4", "req held", 32'(hnd_req[ch]), 1);
                finish_cmd(ch, 1'($urandom), int'($urandom % (DB + 3)));
                chk("R6", "req dropped", 32'(hnd_req[ch]), 0);
            end else begin
                chk("R5", "no req", 32'(hnd_req[ch]), 0);
                exp_cmd[ch] = "!CMD"; exp_evt[ch] = 1'b1;
            end
            check_cmd("R6", ch);
            check_data("R6", ch);
            check_evt("R8");
            wbuf[0] = 8'(2'b01 << ch); wr_reg(8'h22, 1);
            exp_evt[ch] = 1'b0;
            check_evt("R9");
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule